// File: doc/BRIEF.md
# Iterative AND-Rotate-XOR Feistel Block Cipher Core

This block is the round engine of a lightweight 64-bit block cipher. The 64-bit block is held as two 32-bit words. One full Feistel round is computed every clock cycle, for 44 rounds in total. The round function uses only rotations, a bitwise AND and XOR; there are no substitution tables. Each cycle the core puts a round-key index on `round_idx` and reads the matching 32-bit key on `rkey`. The key expansion therefore lives in a separate store, which can be read combinationally in the same cycle.

A one-cycle `start` while the core is idle captures `din` and the `decrypt` mode bit. For encryption the keys are used in ascending order. Decryption is defined as: exchange the two words, run the rounds with the keys in descending order, then exchange the words back. The parameter `USE_INV_ROUND` chooses how decryption is built. When set, a dedicated inverse round is used and no exchange is needed. When clear, the two exchanges are done on either side of the forward round. `busy` is high while rounds run. `done` marks the single cycle in which `dout` holds the result.

Top module: `arx_iter_core`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy` = 0, `done` = 0 and `round_idx` = 0.
- R2: With `decrypt` = 0, the result on `dout` in the `done` cycle equals 44 forward rounds applied to `din`. Word l is bits 63:32 and word r is bits 31:0. The forward round maps (l, r) to ((ROL1(l) & ROL8(l)) ^ ROL2(l) ^ r ^ k, l), and round i uses the key read at index i.
- R3: With `decrypt` = 1, the result equals 44 inverse rounds applied with keys 43 down to 0. The inverse round maps (l, r) to (r, (ROL1(r) & ROL8(r)) ^ ROL2(r) ^ l ^ k). Decrypting an encrypted block with the same key store returns the original block.
- R4: During encryption, `round_idx` reads j in the j-th busy cycle (j = 0..43).
- R5: During decryption, `round_idx` reads 43 - j in the j-th busy cycle.
- R6: `busy` stays high for exactly 44 cycles after the clock edge that accepts `start`. `done` is high in the next cycle, with `busy` low.
- R7: `done` is high for exactly one cycle per block.
- R8: A `start` that arrives while `busy` is high is ignored: the data, the mode, the key order and the completion timing of the running block are unchanged.
- R9: A `start` presented in the `done` cycle is accepted, so blocks can follow each other with no gap.
- R10: Both settings of `USE_INV_ROUND` give identical `dout`, `round_idx`, `busy` and `done` for identical stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a block; honoured only while idle |
| decrypt | input | 1 | 0 = encrypt, 1 = decrypt; captured with `start` |
| din | input | 64 | Input block, l in 63:32, r in 31:0 |
| rkey | input | 32 | Round key for the index on `round_idx` |
| round_idx | output | 6 | Key index needed in the current cycle; 0 while idle |
| busy | output | 1 | Rounds are in progress |
| done | output | 1 | One-cycle pulse; `dout` is valid |
| dout | output | 64 | Output block, l in 63:32, r in 31:0 |

## Verification
Two events can fall in the same cycle: the completion of one block, when `done` is high and `dout` is valid, and the acceptance of the next `start`. The bench provokes this by raising `start` in the very `done` cycle. It then judges that the first result was intact at that moment and that the second block finishes 44 cycles later with its own correct value. A second overlap occurs when a `start` carrying a different block and the opposite mode is driven in the middle of a run. The bench checks that the running block still finishes on time, with an unchanged key-index order and the value its reference model predicts.

// File: rtl/arx_cipher_pkg.sv
package arx_cipher_pkg;

    localparam int WORD_W  = 32;
    localparam int BLOCK_W = 2 * WORD_W;
    localparam int ROT_P   = 1;
    localparam int ROT_Q   = 8;
    localparam int ROT_S   = 2;

    typedef logic [WORD_W-1:0] word_t;

    // l sits in the upper half of the packed block
    typedef struct packed {
        word_t l;
        word_t r;
    } pair_t;

    typedef enum logic {
        OP_ENC = 1'b0,
        OP_DEC = 1'b1
    } op_e;

    function automatic word_t rotl(input word_t w, input int unsigned n);
        return (w << n) | (w >> (WORD_W - n));
    endfunction

    // nonlinear mixing term shared by both round directions
    function automatic word_t mix(input word_t w);
        return (rotl(w, ROT_P) & rotl(w, ROT_Q)) ^ rotl(w, ROT_S);
    endfunction

    function automatic pair_t swap_words(input pair_t p);
        pair_t q;
        q.l = p.r;
        q.r = p.l;
        return q;
    endfunction

endpackage

// File: rtl/arx_round.sv
module arx_round
    import arx_cipher_pkg::*;
#(
    parameter bit USE_INV = 1'b1
) (
    input  pair_t cur,
    input  word_t key,
    input  op_e   op,
    output pair_t nxt
);

    pair_t fwd;

    always_comb begin
        fwd.l = mix(cur.l) ^ cur.r ^ key;
        fwd.r = cur.l;
    end

    generate
        if (USE_INV) begin : g_inv
            pair_t inv;
            always_comb begin
                inv.l = cur.r;
                inv.r = mix(cur.r) ^ cur.l ^ key;
            end
            assign nxt = (op == OP_DEC) ? inv : fwd;
        end else begin : g_fwd
            // decryption handled by word exchange around the forward round
            logic unused_op;
            assign unused_op = ^op;
            assign nxt       = fwd;
        end
    endgenerate

endmodule

// File: rtl/arx_seq.sv
module arx_seq
    import arx_cipher_pkg::*;
#(
    parameter  int ROUNDS = 44,
    localparam int IDX_W  = $clog2(ROUNDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  op_e              op_in,
    output logic             load,
    output logic             busy,
    output logic             done,
    output op_e              op_q,
    output logic [IDX_W-1:0] round_idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ROUNDS - 1);

    logic [IDX_W-1:0] cnt;

    assign load = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
            op_q <= OP_ENC;
        end else begin
            done <= 1'b0;
            if (load) begin
                busy <= 1'b1;
                cnt  <= '0;
                op_q <= op_in;
            end else if (busy) begin
                if (cnt == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    cnt  <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    always_comb begin
        if (!busy)
            round_idx = '0;
        else if (op_q == OP_DEC)
            round_idx = LAST - cnt;
        else
            round_idx = cnt;
    end

endmodule

// File: rtl/arx_state.sv
module arx_state
    import arx_cipher_pkg::*;
#(
    parameter bit USE_INV = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  busy,
    input  op_e   op_in,
    input  op_e   op_q,
    input  pair_t din,
    input  pair_t nxt,
    output pair_t cur,
    output pair_t dout
);

    logic swap_in;
    logic swap_out;

    assign swap_in  = !USE_INV && (op_in == OP_DEC);
    assign swap_out = !USE_INV && (op_q == OP_DEC);

    always_ff @(posedge clk) begin
        if (rst)
            cur <= '0;
        else if (load)
            cur <= swap_in ? swap_words(din) : din;
        else if (busy)
            cur <= nxt;
    end

    assign dout = swap_out ? swap_words(cur) : cur;

endmodule

// File: rtl/arx_iter_core.sv
module arx_iter_core
    import arx_cipher_pkg::*;
#(
    parameter  int ROUNDS        = 44,
    parameter  bit USE_INV_ROUND = 1'b1,
    localparam int IDX_W         = $clog2(ROUNDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               decrypt,
    input  logic [BLOCK_W-1:0] din,
    input  logic [WORD_W-1:0]  rkey,
    output logic [IDX_W-1:0]   round_idx,
    output logic               busy,
    output logic               done,
    output logic [BLOCK_W-1:0] dout
);

    op_e   op_in;
    op_e   op_q;
    logic  load;
    pair_t cur;
    pair_t nxt;
    pair_t res;

    assign op_in = decrypt ? OP_DEC : OP_ENC;

    arx_seq #(.ROUNDS(ROUNDS)) seq_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .op_in    (op_in),
        .load     (load),
        .busy     (busy),
        .done     (done),
        .op_q     (op_q),
        .round_idx(round_idx)
    );

    arx_round #(.USE_INV(USE_INV_ROUND)) round_i (
        .cur(cur),
        .key(rkey),
        .op (op_q),
        .nxt(nxt)
    );

    arx_state #(.USE_INV(USE_INV_ROUND)) state_i (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .busy (busy),
        .op_in(op_in),
        .op_q (op_q),
        .din  (pair_t'(din)),
        .nxt  (nxt),
        .cur  (cur),
        .dout (res)
    );

    assign dout = res;

endmodule

// File: rtl/arx_iter_core_chk.sv
module arx_iter_core_chk
    import arx_cipher_pkg::*;
#(
    parameter  int ROUNDS = 44,
    localparam int IDX_W  = $clog2(ROUNDS)
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input op_e              op_q,
    input logic [IDX_W-1:0] round_idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ROUNDS - 1);

    // R1
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done && round_idx == '0));

    // R7
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    p_done_not_busy_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R6
    p_done_after_last_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && $past(round_idx) == ((op_q == OP_DEC) ? '0 : LAST)));

    // R4
    p_idx_up_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && op_q == OP_ENC) |->
            (round_idx == IDX_W'($past(round_idx) + 1'b1)));

    // R5
    p_idx_down_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && op_q == OP_DEC) |->
            (round_idx == IDX_W'($past(round_idx) - 1'b1)));

    // R8
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(op_q));

endmodule

bind arx_iter_core arx_iter_core_chk #(.ROUNDS(ROUNDS)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .op_q     (op_q),
    .round_idx(round_idx)
);

// File: tb/arx_iter_core_tb_top.sv
module arx_iter_core_tb_top;

    localparam int ROUNDS = 44;
    localparam int IDX_W  = $clog2(ROUNDS);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             decrypt = 1'b0;
    logic [63:0]      din = '0;
    logic [31:0]      seed = 32'h1234_5678;
    logic [31:0]      rkey_a, rkey_b;
    logic [IDX_W-1:0] idx_a, idx_b;
    logic             busy_a, busy_b, done_a, done_b;
    logic [63:0]      dout_a, dout_b;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    function automatic logic [31:0] kf(input logic [IDX_W-1:0] i, input logic [31:0] s);
        logic [31:0] x;
        x = s ^ {i, 26'h0} ^ {26'h0, i};
        x = x * 32'h9E37_79B1;
        return x ^ (x >> 15);
    endfunction

    assign rkey_a = kf(idx_a, seed);
    assign rkey_b = kf(idx_b, seed);

    arx_iter_core #(.ROUNDS(ROUNDS), .USE_INV_ROUND(1'b1)) dut_i (
        .clk(clk), .rst(rst), .start(start), .decrypt(decrypt), .din(din),
        .rkey(rkey_a), .round_idx(idx_a), .busy(busy_a), .done(done_a), .dout(dout_a)
    );

    arx_iter_core #(.ROUNDS(ROUNDS), .USE_INV_ROUND(1'b0)) dut_swap_i (
        .clk(clk), .rst(rst), .start(start), .decrypt(decrypt), .din(din),
        .rkey(rkey_b), .round_idx(idx_b), .busy(busy_b), .done(done_b), .dout(dout_b)
    );

    function automatic logic [31:0] ref_f(input logic [31:0] w);
        return ({w[30:0], w[31]} & {w[23:0], w[31:24]}) ^ {w[29:0], w[31:30]};
    endfunction

    function automatic logic [63:0] ref_enc(input logic [63:0] d, input logic [31:0] s);
        logic [31:0] l, r, t;
        l = d[63:32];
        r = d[31:0];
        for (int i = 0; i < ROUNDS; i++) begin
            t = l;
            l = ref_f(l) ^ r ^ kf(IDX_W'(i), s);
            r = t;
        end
        return {l, r};
    endfunction

    function automatic logic [63:0] ref_dec(input logic [63:0] d, input logic [31:0] s);
        logic [31:0] l, r, t;
        l = d[63:32];
        r = d[31:0];
        for (int i = ROUNDS - 1; i >= 0; i--) begin
            t = r;
            r = ref_f(r) ^ l ^ kf(IDX_W'(i), s);
            l = t;
        end
        return {l, r};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Starts a block at the current negedge; returns at the negedge of the done cycle.
    task automatic do_block(input logic [63:0] d, input bit dec, input int poke_at,
                            output logic [63:0] ra, output logic [63:0] rb);
        bit idx_ok = 1'b1;
        bit busy_ok = 1'b1;
        bit match_ok = 1'b1;
        logic [IDX_W-1:0] expi;
        din     = d;
        decrypt = dec;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j < ROUNDS; j++) begin
            expi = dec ? IDX_W'(ROUNDS - 1 - j) : IDX_W'(j);
            if (idx_a != expi) idx_ok = 1'b0;
            if (!busy_a || done_a) busy_ok = 1'b0;
            if (idx_a != idx_b || busy_a != busy_b || done_a != done_b) match_ok = 1'b0;
            if (j == poke_at) begin
                din     = ~d;
                decrypt = !dec;
                start   = 1'b1;
            end else begin
                din     = d;
                decrypt = dec;
                start   = 1'b0;
            end
            @(negedge clk);
        end
        start   = 1'b0;
        decrypt = dec;
        if (dec) chk(idx_ok, "R5 descending key index", 64'(idx_a), 64'(0));
        else     chk(idx_ok, "R4 ascending key index", 64'(idx_a), 64'(ROUNDS - 1));
        chk(busy_ok && !busy_a && done_a, "R6 busy span and done timing",
            {busy_a, done_a}, 64'b01);
        chk(match_ok && !busy_b && done_b, "R10 variant control match",
            {busy_b, done_b}, {busy_a, done_a});
        ra = dout_a;
        rb = dout_b;
    endtask

    task automatic finish_report();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        finish_report();
    end

    initial begin
        logic [63:0] ra, rb, ca, e, pat, ra2, rb2;

        // R1
        repeat (3) @(negedge clk);
        chk(!busy_a && !done_a && idx_a == '0, "R1 state in reset",
            {busy_a, done_a, 56'(idx_a)}, 64'(0));
        rst = 1'b0;
        @(negedge clk);
        chk(!busy_a && !done_a && idx_a == '0 && !busy_b && !done_b, "R1 state after reset",
            {busy_a, done_a, 56'(idx_a)}, 64'(0));

        // Sweep: directed plus walking-one patterns, encrypt then decrypt
        for (int p = 0; p < 70; p++) begin
            if (p == 0)      pat = 64'h0;
            else if (p == 1) pat = '1;
            else if (p == 2) pat = 64'h656b_696c_2064_6e75;
            else if (p == 3) pat = 64'hdead_beef_0123_4567;
            else if (p == 4) pat = 64'h8000_0000_0000_0001;
            else if (p == 5) pat = 64'hffff_ffff_0000_0000;
            else             pat = 64'h1 << (p - 6);
            seed = 32'h1234_5678 ^ (32'(p) * 32'h0101_0111);
            @(negedge clk);

            do_block(pat, 1'b0, -1, ra, rb);
            e = ref_enc(pat, seed);
            chk(ra === e, "R2 encrypt value", ra, e);
            chk(rb === ra, "R10 variant encrypt match", rb, ra);
            ca = ra;
            @(negedge clk);
            chk(!done_a && !busy_a, "R7 done lasts one cycle", {busy_a, done_a}, 64'(0));

            do_block(ca, 1'b1, -1, ra, rb);
            chk(ra === pat, "R3 decrypt round trip", ra, pat);
            chk(rb === ra, "R10 variant decrypt match", rb, ra);
            @(negedge clk);

            do_block(pat, 1'b1, -1, ra, rb);
            e = ref_dec(pat, seed);
            chk(ra === e, "R3 decrypt value", ra, e);
            chk(rb === e, "R10 variant decrypt value", rb, e);
            @(negedge clk);
        end

        // R8: starts during busy, other data and mode, at several positions
        seed = 32'h0bad_cafe;
        for (int q = 0; q < 4; q++) begin
            int at;
            at = (q == 0) ? 0 : (q == 1) ? 7 : (q == 2) ? 20 : ROUNDS - 1;
            pat = 64'h0f1e_2d3c_4b5a_6978 ^ (64'(q) << 40);
            @(negedge clk);
            do_block(pat, q[0], at, ra, rb);
            e = q[0] ? ref_dec(pat, seed) : ref_enc(pat, seed);
            chk(ra === e, "R8 start during busy ignored", ra, e);
            chk(rb === e, "R8 start during busy ignored variant", rb, e);
            @(negedge clk);
            chk(!busy_a && !done_a, "R8 no extra block launched", {busy_a, done_a}, 64'(0));
        end

        // R9: start in the done cycle
        seed = 32'h7777_1111;
        pat  = 64'h0011_2233_4455_6677;
        @(negedge clk);
        do_block(pat, 1'b0, -1, ra, rb);
        e = ref_enc(pat, seed);
        chk(ra === e, "R9 first result at done", ra, e);
        do_block(ra, 1'b1, -1, ra2, rb2);
        chk(ra2 === pat, "R9 back-to-back second block", ra2, pat);
        chk(rb2 === pat, "R9 back-to-back second block variant", rb2, pat);
        do_block(64'hcafe_f00d_1357_9bdf, 1'b1, -1, ra2, rb2);
        e = ref_dec(64'hcafe_f00d_1357_9bdf, seed);
        chk(ra2 === e, "R9 third chained block", ra2, e);
        @(negedge clk);
        chk(!done_a && !busy_a, "R7 done drops after chain", {busy_a, done_a}, 64'(0));

        finish_report();
    end

endmodule